// File: doc/BRIEF.md
# Serial Latch Programming Port

This block is the digital control port of a synthesizer-style device. A host drives three slow pins: a serial clock, a serial data line and a load strobe. The block samples the pins with its own system clock. It shifts one bit into a 21-bit word on each rising edge of the serial clock, most significant bit first. On a rising edge of the load strobe it copies the upper 19 bits of the word into one of four holding latches. The two lowest bits of the word, which are the last two bits shifted in, pick the latch.

A chip-enable pin and a power-down bit in the function latch together produce the power-down state and the drive enable of the charge-pump output. A 3-bit field of the function latch steers one of three monitor sources (lock detect, scaled RF divider, scaled reference divider) to a single monitor output. The other codes of that field hold the output low. Writing the initialization latch also loads the function latch and sends a one-cycle counter-clear pulse.

Top module: `ser_latch_port`

## Requirements
- R1: Each of the three serial pins is sampled on every rising edge of `clk`. A rising edge of `sclk` is acted on at the second `clk` edge after the first edge that samples it high. At that edge the 21-bit word shifts left by one bit and takes the sampled `sdata` bit as its new bit 0, so the first bit sent ends up as bit 20.
- R2: A rising edge of `sload` is detected with the same timing as R1. It copies word bits 20..2 into the latch selected by word bits 1..0: code 00 loads `ref_word`, code 01 loads `n_word` and code 10 loads `func_word`. The latches that are not selected keep their values.
- R3: A strobe commits only once, even while `sload` stays high and more bits are shifted in. Bits shifted while no strobe edge occurs never alter any latch.
- R4: Code 11 loads `func_word` and raises `cnt_clear` for exactly one `clk` cycle. `ref_word` and `n_word` keep their values.
- R5: After reset, all three latch outputs are zero, `cnt_clear` is low, `cp_drive` is low and `mon_out` is low.
- R6: While `chip_en` is low, `pwr_down` is high and `cp_drive` is low, whatever the latch contents.
- R7: While `chip_en` is high, `pwr_down` equals `func_word[3]`. `cp_drive` is high only when `pwr_down` is low and the function latch has been written (by code 10 or 11) since reset.
- R8: The monitor select is `func_word[2:0]`. Code 000 drives `mon_out` low, 001 passes `lock_det`, 010 passes `rf_div` and 011 passes `ref_div`.
- R9: Select codes 100 through 111 hold `mon_out` low, whatever the levels of the three sources.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk | input | 1 | Serial clock pin |
| sdata | input | 1 | Serial data pin, most significant bit first |
| sload | input | 1 | Load strobe pin |
| chip_en | input | 1 | Chip enable pin; low forces power-down |
| lock_det | input | 1 | Monitor source: lock detect |
| rf_div | input | 1 | Monitor source: scaled RF divider output |
| ref_div | input | 1 | Monitor source: scaled reference divider output |
| ref_word | output | 19 | Reference counter latch |
| n_word | output | 19 | N counter latch |
| func_word | output | 19 | Function latch |
| cnt_clear | output | 1 | One-cycle counter clear from an initialization write |
| pwr_down | output | 1 | Power-down state |
| cp_drive | output | 1 | Charge-pump output enable; low means high impedance |
| mon_out | output | 1 | Monitor multiplexer output |

## Verification
A corrupted shift word or a wrong decode of the control code shows up at the latch outputs on the cycle after the strobe commits. Either the wrong latch changes or the right latch takes the wrong payload. A reference model compared on every clock catches this within one cycle. A repeated commit or a missing one-cycle clear pulse appears as an extra change on a latch output or on `cnt_clear`. A wrong power or monitor decode is visible on the next comparison after `chip_en`, a source level or the function latch changes.

// File: rtl/ser_latch_port.sv
module ser_latch_port #(
  parameter int WORD_W = 21,
  parameter int CTRL_W = 2,
  parameter int SEL_W  = 3,
  parameter int PD_BIT = 3
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       sclk,
  input  logic                       sdata,
  input  logic                       sload,
  input  logic                       chip_en,
  input  logic                       lock_det,
  input  logic                       rf_div,
  input  logic                       ref_div,
  output logic [WORD_W-CTRL_W-1:0]   ref_word,
  output logic [WORD_W-CTRL_W-1:0]   n_word,
  output logic [WORD_W-CTRL_W-1:0]   func_word,
  output logic                       cnt_clear,
  output logic                       pwr_down,
  output logic                       cp_drive,
  output logic                       mon_out
);
  localparam int PAY_W = WORD_W - CTRL_W;

  logic [2:0]        sclk_q, sload_q;
  logic [1:0]        sdata_q;
  logic [WORD_W-1:0] shreg;
  logic              func_set;
  logic              shift_rise, load_rise;
  logic [CTRL_W-1:0] code;
  logic [PAY_W-1:0]  payload;

  assign shift_rise = sclk_q[1] & ~sclk_q[2];
  assign load_rise  = sload_q[1] & ~sload_q[2];
  assign code       = shreg[CTRL_W-1:0];
  assign payload    = shreg[WORD_W-1:CTRL_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_q  <= '0;
      sload_q <= '0;
      sdata_q <= '0;
    end else begin
      sclk_q  <= {sclk_q[1:0], sclk};
      sload_q <= {sload_q[1:0], sload};
      sdata_q <= {sdata_q[0], sdata};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) shreg <= '0;
    else if (shift_rise) shreg <= {shreg[WORD_W-2:0], sdata_q[1]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ref_word  <= '0;
      n_word    <= '0;
      func_word <= '0;
      func_set  <= 1'b0;
      cnt_clear <= 1'b0;
    end else begin
      cnt_clear <= 1'b0;
      if (load_rise) begin
        case (code)
          2'd0: ref_word <= payload;
          2'd1: n_word   <= payload;
          default: begin
            func_word <= payload;
            func_set  <= 1'b1;
            cnt_clear <= (code == 2'd3);
          end
        endcase
      end
    end
  end

  assign pwr_down = ~chip_en | func_word[PD_BIT];
  assign cp_drive = func_set & ~pwr_down;

  always_comb begin
    case (func_word[SEL_W-1:0])
      3'd1:    mon_out = lock_det;
      3'd2:    mon_out = rf_div;
      3'd3:    mon_out = ref_div;
      default: mon_out = 1'b0;
    endcase
  end

  a_r3_latches_hold_without_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    !load_rise |=> ($stable(ref_word) && $stable(n_word) && $stable(func_word)));

  a_r3_single_commit: assert property (@(posedge clk) disable iff (!rst_n)
    load_rise |=> !load_rise);

  a_r4_clear_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_clear |=> !cnt_clear);

  a_r4_clear_follows_init: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cnt_clear) |-> $past(load_rise));

  a_r6_ce_low_tristate: assert property (@(posedge clk) disable iff (!rst_n)
    !chip_en |-> (pwr_down && !cp_drive));

  a_r9_unused_sel_low: assert property (@(posedge clk) disable iff (!rst_n)
    func_word[SEL_W-1] |-> !mon_out);
endmodule

// File: tb/sim_ser_latch_port.sv
module sim_ser_latch_port;
  logic clk = 1'b0, rst_n = 1'b0;
  logic sclk = 0, sdata = 0, sload = 0, chip_en = 1;
  logic lock_det = 0, rf_div = 0, ref_div = 0;
  logic [18:0] ref_word, n_word, func_word;
  logic cnt_clear, pwr_down, cp_drive, mon_out;

  int tests = 0, fails = 0, clr_seen = 0, cycles = 0;

  ser_latch_port u0 (.clk(clk), .rst_n(rst_n), .sclk(sclk), .sdata(sdata), .sload(sload),
    .chip_en(chip_en), .lock_det(lock_det), .rf_div(rf_div), .ref_div(ref_div),
    .ref_word(ref_word), .n_word(n_word), .func_word(func_word), .cnt_clear(cnt_clear),
    .pwr_down(pwr_down), .cp_drive(cp_drive), .mon_out(mon_out));

  always #10 clk = ~clk;

  // reference model
  logic [20:0] m_sh;
  logic [18:0] m_ref, m_n, m_fn;
  logic m_cfg, m_clr;
  logic [2:0] hist[$];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_sh = '0; m_ref = '0; m_n = '0; m_fn = '0; m_cfg = 0; m_clr = 0;
      hist.delete();
      repeat (3) hist.push_back(3'b000);
    end else begin
      hist.push_back({sclk, sdata, sload});
      m_clr = 0;
      if (hist[$-2][0] && !hist[$-3][0]) begin
        if (m_sh[1:0] == 2'd0) m_ref = m_sh[20:2];
        else if (m_sh[1:0] == 2'd1) m_n = m_sh[20:2];
        else begin
          m_fn = m_sh[20:2]; m_cfg = 1;
          if (m_sh[1:0] == 2'd3) m_clr = 1;
        end
      end
      if (hist[$-2][2] && !hist[$-3][2]) m_sh = {m_sh[19:0], hist[$-2][1]};
      if (hist.size() > 8) void'(hist.pop_front());
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic exp_mon(input logic [2:0] s);
    case (s)
      3'd1: return lock_det;
      3'd2: return rf_div;
      3'd3: return ref_div;
      default: return 1'b0;
    endcase
  endfunction

  always @(negedge clk) begin
    cycles++;
    if (cnt_clear) clr_seen++;
    if (rst_n) begin
      chk("R2 ref_word", ref_word, m_ref);
      chk("R2 n_word", n_word, m_n);
      chk("R2 func_word", func_word, m_fn);
      chk("R4 cnt_clear", cnt_clear, m_clr);
      if (!chip_en) begin
        chk("R6 pwr_down", pwr_down, 1);
        chk("R6 cp_drive", cp_drive, 0);
      end else begin
        chk("R7 pwr_down", pwr_down, m_fn[3]);
        chk("R7 cp_drive", cp_drive, m_cfg & ~m_fn[3]);
      end
      if (m_fn[2]) chk("R9 mon_out", mon_out, 0);
      else chk("R8 mon_out", mon_out, exp_mon(m_fn[2:0]));
    end
  end

  always @(negedge clk) if (cycles > 150000) begin
    fails++;
    $display("FAIL watchdog actual=%0d expected<150000", cycles);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  task automatic wclk(input int n);
    repeat (n) @(posedge clk);
    #3;
  endtask

  task automatic shift_bits(input logic [20:0] w, input int nbits);
    for (int i = 20; i > 20 - nbits; i--) begin
      sdata = w[i]; wclk(3);
      sclk = 1; wclk(3);
      sclk = 0;
    end
    wclk(3);
  endtask

  task automatic strobe();
    sload = 1; wclk(5);
    sload = 0; wclk(5);
  endtask

  task automatic send(input logic [18:0] pay, input logic [1:0] c);
    shift_bits({pay, c}, 21);
    strobe();
  endtask

  initial begin
    wclk(2);
    @(negedge clk);
    // R5 reset state
    chk("R5 ref_word", ref_word, 0); chk("R5 n_word", n_word, 0);
    chk("R5 func_word", func_word, 0); chk("R5 cnt_clear", cnt_clear, 0);
    chk("R5 cp_drive", cp_drive, 0); chk("R5 mon_out", mon_out, 0);
    rst_n = 1;
    wclk(4);
    chk("R5 cp_drive after release", cp_drive, 0);

    // R1, R2 writes to each latch
    send(19'h5A3C1, 2'd0);
    chk("R1 R2 ref payload", ref_word, 19'h5A3C1);
    chk("R2 n untouched", n_word, 0);
    send(19'h2B00F, 2'd1);
    chk("R2 n payload", n_word, 19'h2B00F);
    chk("R2 ref held", ref_word, 19'h5A3C1);
    send(19'h40001, 2'd2);
    chk("R2 func payload", func_word, 19'h40001);
    chk("R7 cp_drive on", cp_drive, 1);

    // R3 partial word without strobe
    shift_bits(21'h1FFFFF, 10);
    wclk(10);
    chk("R3 partial ref", ref_word, 19'h5A3C1);
    chk("R3 partial n", n_word, 19'h2B00F);
    chk("R3 partial func", func_word, 19'h40001);

    // R3 strobe held high while new word shifts in
    shift_bits({19'h11111, 2'd1}, 21);
    sload = 1; wclk(5);
    chk("R3 first commit", n_word, 19'h11111);
    shift_bits({19'h22222, 2'd1}, 21);
    chk("R3 no second commit", n_word, 19'h11111);
    sload = 0; wclk(5);
    chk("R3 no commit on fall", n_word, 19'h11111);

    // R4 initialization word
    clr_seen = 0;
    send(19'h00002, 2'd3);
    chk("R4 func by init", func_word, 19'h00002);
    chk("R4 one clear pulse", clr_seen, 1);
    chk("R4 ref held", ref_word, 19'h5A3C1);

    // R8 R9 monitor select
    for (int s = 0; s < 8; s++) begin
      send({16'h0, s[2:0]}, 2'd2);
      for (int p = 0; p < 8; p++) begin
        {lock_det, rf_div, ref_div} = p[2:0];
        wclk(2);
        @(negedge clk);
        if (s >= 4) chk("R9 unused code low", mon_out, 0);
        else chk("R8 mux source", mon_out, exp_mon(s[2:0]));
        wclk(1);
      end
    end

    // R6 R7 power-down
    send(19'h00009, 2'd2);
    chk("R7 pd bit sets pwr_down", pwr_down, 1);
    chk("R7 pd bit tristate", cp_drive, 0);
    send(19'h00001, 2'd2);
    chip_en = 0; wclk(3);
    chk("R6 ce low pwr_down", pwr_down, 1);
    chk("R6 ce low tristate", cp_drive, 0);
    chip_en = 1; wclk(3);
    chk("R7 ce high drive", cp_drive, 1);

    wclk(5);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule